// File: doc/BRIEF.md
# Real-Time-Clock Status and Change-Flag Register Block

This block holds the status and flag state of a real-time-clock peripheral on an 8-bit parallel processor bus. It gathers hardware event strobes (interrupt causes, a power-fail pin, per-unit time rollover pulses, an oscillator-fail detect) into bus-readable bits. Each bit follows its own clearing rule. Cause bits clear when software writes a one to them. The power-fail bit is held clear by the level of the power-fail pin. Rollover flags clear when software reads them. One bit has two meanings: it reads as the oscillator-fail flag and, when written, selects the supply mode.

A small bus state machine turns level read and write strobes into exactly one action per strobe. It has four states. BUS_IDLE waits for a strobe. BUS_READ holds the captured read data while the read strobe stays high. BUS_RCLR is a single cycle after the read strobe falls, in which the flags that were returned are cleared. BUS_WRITE waits out a held write strobe. The named transitions are:

- read-start: BUS_IDLE to BUS_READ, taken when the read strobe is high.
- write-start: BUS_IDLE to BUS_WRITE, taken when only the write strobe is high.
- read-end: BUS_READ to BUS_RCLR, taken when the read strobe falls.
- clear-done: BUS_RCLR to BUS_IDLE, taken unconditionally.
- write-end: BUS_WRITE to BUS_IDLE, taken when the write strobe falls.

Top module: `rtc_flag_regs`

## Requirements
- R1: After power-on reset, the status register (address 0) reads 0x00 with both interrupt inputs low and the power-fail pin high. The flag register (address 3) reads 0x40, `blk_sel` and `test_en` are 0, and `single_supply` is 1.
- R2: The status register decodes at address 0 whether `blk_sel` is 0 or 1. The flag register decodes at address 3 only while `blk_sel` is 0. Any other read returns 0x00 and clears nothing.
- R3: Status bit 0 is read-only and reads 1 whenever `irq_pend` or `mfo_pend` is high.
- R4: Status bit 2 is set by `alarm_evt` and status bit 3 by `tick_evt`, with no masking. A read does not clear them. Writing a one to the bit's position at address 0 clears it, and writing a zero has no effect.
- R5: Status bit 1 is set by `pf_evt` while `pf_pin` is 0. It is held at 0 for as long as `pf_pin` is 1, and writing to it has no effect.
- R6: Status bit 6 (`blk_sel`) and bit 7 (`test_en`) are read/write, loaded by a write to address 0. Status bits 4 and 5 always read 0.
- R7: Flag bits 0 to 5 are set by the matching bit of `roll`. A read returns the value before clearing. After the read strobe falls, exactly the bits that read as 1 are cleared. Writes do not change flag bits 0 to 5.
- R8: Flag bit 6 reads the oscillator-fail flag. Reset and `osc_fail_evt` set it. It clears only on `clk_start_wr` while `osc_running` is 1, and `osc_fail_evt` wins over a clear in the same cycle.
- R9: Writing address 3 loads bit 6 of the write data into `single_supply` (1 = single supply, 0 = battery-backed). `osc_fail_evt` forces it to 1, and such a write does not change the oscillator-fail flag.
- R10: When a hardware set and a software clear of the same bit fall in the same cycle, the bit ends set.
- R11: Each strobe acts once: a write takes effect in its first cycle only. Read data holds until the next read. When read and write strobes rise together, the read is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, level |
| rd_stb | input | 1 | Read strobe, level |
| irq_pend | input | 1 | Interrupt pending on the interrupt output |
| mfo_pend | input | 1 | Interrupt pending on the multi-function output |
| pf_pin | input | 1 | Power-fail pin level, 1 holds status bit 1 clear |
| pf_evt | input | 1 | Power-fail interrupt event pulse |
| alarm_evt | input | 1 | Cause event for status bit 2 |
| tick_evt | input | 1 | Cause event for status bit 3 |
| roll | input | 6 | Per-unit time rollover pulses |
| osc_fail_evt | input | 1 | Oscillator-fail detect pulse |
| clk_start_wr | input | 1 | A one was written to the clock start/stop bit |
| osc_running | input | 1 | Oscillator is running |
| rdata | output | 8 | Read data, held until the next read |
| blk_sel | output | 1 | Register-block select |
| test_en | output | 1 | Test-mode register enable |
| single_supply | output | 1 | Supply-mode select |

## Verification
A wrong bus state shows within one strobe. A stuck BUS_READ keeps flags from clearing, so the second read still returns them. A missed BUS_RCLR has the same effect. A write that fires more than once erases a cause event that arrives while the strobe is held. A wrong snapshot or set-clear priority shows on the next read of the flag register as a lost or stale flag. A wrong cause or supply-mode bit shows at once on the next status read or on `single_supply`.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
    localparam int FLAG_W = 6;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_RCLR  = 2'd2,
        BUS_WRITE = 2'd3
    } bus_state_e;
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_flag_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rd_stb,
    input  logic wr_stb,
    output logic rd_fire,
    output logic wr_fire,
    output logic rd_clr
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!por_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (rd_stb)      state_d = BUS_READ;   // read-start
                else if (wr_stb) state_d = BUS_WRITE;  // write-start
            end
            BUS_READ:  if (!rd_stb) state_d = BUS_RCLR;  // read-end
            BUS_RCLR:  state_d = BUS_IDLE;              // clear-done
            BUS_WRITE: if (!wr_stb) state_d = BUS_IDLE;  // write-end
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_fire = (state_q == BUS_IDLE) && rd_stb;
        wr_fire = (state_q == BUS_IDLE) && wr_stb && !rd_stb;
        rd_clr  = (state_q == BUS_RCLR);
    end
endmodule

// File: rtl/rtc_main_status.sv
module rtc_main_status (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       pf_pin,
    input  logic       pf_evt,
    input  logic       alarm_evt,
    input  logic       tick_evt,
    output logic [3:1] cause_q,
    output logic       blk_sel_q,
    output logic       test_en_q
);
    logic [3:1] cause_d;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[5:4], wdata[1:0]};

    always_comb begin
        cause_d[1] = pf_pin ? 1'b0 : (cause_q[1] | pf_evt);
        cause_d[2] = alarm_evt | (cause_q[2] & !(wr_hit && wdata[2]));
        cause_d[3] = tick_evt  | (cause_q[3] & !(wr_hit && wdata[3]));
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_q   <= '0;
            blk_sel_q <= 1'b0;
            test_en_q <= 1'b0;
        end else begin
            cause_q <= cause_d;
            if (wr_hit) begin
                blk_sel_q <= wdata[6];
                test_en_q <= wdata[7];
            end
        end
    end
endmodule

// File: rtl/rtc_periodic_flags.sv
module rtc_periodic_flags
    import rtc_flag_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [FLAG_W-1:0] roll,
    input  logic              rd_fire,
    input  logic              rd_sel,
    input  logic              rd_clr,
    input  logic              wr_hit,
    input  logic              wr_mode,
    input  logic              osc_fail_evt,
    input  logic              clk_start_wr,
    input  logic              osc_running,
    output logic [FLAG_W-1:0] flag_q,
    output logic              osc_flag_q,
    output logic              single_q
);
    logic [FLAG_W-1:0] snap_q;
    logic [FLAG_W-1:0] flag_d;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        assign flag_d[i] = roll[i] | (flag_q[i] & !(rd_clr && snap_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag_q     <= '0;
            snap_q     <= '0;
            osc_flag_q <= 1'b1;
            single_q   <= 1'b1;
        end else begin
            flag_q <= flag_d;
            if (rd_fire) snap_q <= rd_sel ? flag_q : '0;
            if (osc_fail_evt)                     osc_flag_q <= 1'b1;
            else if (clk_start_wr && osc_running) osc_flag_q <= 1'b0;
            if (osc_fail_evt)  single_q <= 1'b1;
            else if (wr_hit)   single_q <= wr_mode;
        end
    end
endmodule

// File: rtl/rtc_flag_regs.sv
module rtc_flag_regs
    import rtc_flag_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int MAIN_ADDR  = 0,
    parameter int PFLAG_ADDR = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              irq_pend,
    input  logic              mfo_pend,
    input  logic              pf_pin,
    input  logic              pf_evt,
    input  logic              alarm_evt,
    input  logic              tick_evt,
    input  logic [FLAG_W-1:0] roll,
    input  logic              osc_fail_evt,
    input  logic              clk_start_wr,
    input  logic              osc_running,
    output logic [7:0]        rdata,
    output logic              blk_sel,
    output logic              test_en,
    output logic              single_supply
);
    localparam logic [ADDR_W-1:0] MAIN_A  = MAIN_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PFLAG_A = PFLAG_ADDR[ADDR_W-1:0];

    logic              rd_fire, wr_fire, rd_clr;
    logic              main_sel, pflag_sel;
    logic [3:1]        cause_bits;
    logic [FLAG_W-1:0] pflag_bits;
    logic              osc_flag;
    logic [7:0]        rd_val;
    logic [7:0]        rdata_q;

    assign main_sel  = (addr == MAIN_A);
    assign pflag_sel = (addr == PFLAG_A) && !blk_sel;

    rtc_bus_fsm u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire),
        .rd_clr  (rd_clr)
    );

    rtc_main_status u_main (
        .clk       (clk),
        .por_n     (por_n),
        .wr_hit    (wr_fire && main_sel),
        .wdata     (wdata),
        .pf_pin    (pf_pin),
        .pf_evt    (pf_evt),
        .alarm_evt (alarm_evt),
        .tick_evt  (tick_evt),
        .cause_q   (cause_bits),
        .blk_sel_q (blk_sel),
        .test_en_q (test_en)
    );

    rtc_periodic_flags u_pflag (
        .clk          (clk),
        .por_n        (por_n),
        .roll         (roll),
        .rd_fire      (rd_fire),
        .rd_sel       (pflag_sel),
        .rd_clr       (rd_clr),
        .wr_hit       (wr_fire && pflag_sel),
        .wr_mode      (wdata[6]),
        .osc_fail_evt (osc_fail_evt),
        .clk_start_wr (clk_start_wr),
        .osc_running  (osc_running),
        .flag_q       (pflag_bits),
        .osc_flag_q   (osc_flag),
        .single_q     (single_supply)
    );

    always_comb begin
        if (main_sel)
            rd_val = {test_en, blk_sel, 2'b00, cause_bits, irq_pend | mfo_pend};
        else if (pflag_sel)
            rd_val = {1'b0, osc_flag, pflag_bits};
        else
            rd_val = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!por_n)       rdata_q <= 8'h00;
        else if (rd_fire) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rtc_flag_checker.sv
module rtc_flag_checker #(
    parameter int ADDR_W    = 5,
    parameter int MAIN_ADDR = 0
) (
    input logic              clk,
    input logic              por_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              pf_pin,
    input logic [5:0]        roll,
    input logic              osc_fail_evt,
    input logic              clk_start_wr,
    input logic              osc_running,
    input logic [3:1]        cause_bits,
    input logic [5:0]        pflag_bits,
    input logic              osc_flag,
    input logic              single_supply,
    input logic [7:0]        rdata
);
    // R5: pin level holds the power-fail bit clear
    a_r5_pin_holds_clear: assert property (@(posedge clk) disable iff (!por_n)
        pf_pin |=> !cause_bits[1]);

    // R4: bit 2 only falls after a write of one to it
    a_r4_w1c_only: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cause_bits[2]) |-> $past(wr_stb && (addr == MAIN_ADDR[ADDR_W-1:0]) && wdata[2]));

    // R8: oscillator-fail flag falls only on a start write with oscillator running
    a_r8_osc_clear_needs_run: assert property (@(posedge clk) disable iff (!por_n)
        $fell(osc_flag) |-> $past(clk_start_wr && osc_running));

    // R8: fail event sets the flag
    a_r8_osc_fail_sets: assert property (@(posedge clk) disable iff (!por_n)
        osc_fail_evt |=> osc_flag);

    // R9: fail event forces single-supply mode
    a_r9_single_forced: assert property (@(posedge clk) disable iff (!por_n)
        osc_fail_evt |=> single_supply);

    // R10: a rollover pulse always leaves its flag set
    a_r10_roll_wins: assert property (@(posedge clk) disable iff (!por_n)
        (roll != 6'd0) |=> ((pflag_bits & $past(roll)) == $past(roll)));

    // R11: read data only changes on a read
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!por_n)
        !rd_stb |=> $stable(rdata));
endmodule

bind rtc_flag_regs rtc_flag_checker #(.ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .addr          (addr),
    .wdata         (wdata),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .pf_pin        (pf_pin),
    .roll          (roll),
    .osc_fail_evt  (osc_fail_evt),
    .clk_start_wr  (clk_start_wr),
    .osc_running   (osc_running),
    .cause_bits    (cause_bits),
    .pflag_bits    (pflag_bits),
    .osc_flag      (osc_flag),
    .single_supply (single_supply),
    .rdata         (rdata)
);

// File: tb/rtc_flag_regs_test.sv
module rtc_flag_regs_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0;
    logic       irq_pend = 1'b0, mfo_pend = 1'b0;
    logic       pf_pin = 1'b1, pf_evt = 1'b0;
    logic       alarm_evt = 1'b0, tick_evt = 1'b0;
    logic [5:0] roll = '0;
    logic       osc_fail_evt = 1'b0, clk_start_wr = 1'b0, osc_running = 1'b0;
    logic [7:0] rdata;
    logic       blk_sel, test_en, single_supply;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] got;

    // each entry: {rollover pattern, expected flag read}
    localparam logic [15:0] VEC [0:8] = '{
        16'h0101, 16'h0202, 16'h0404, 16'h0808, 16'h1010,
        16'h2020, 16'h3F3F, 16'h1515, 16'h2A2A
    };

    always #10 clk = ~clk;

    rtc_flag_regs uut (
        .clk(clk), .por_n(por_n), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .irq_pend(irq_pend),
        .mfo_pend(mfo_pend), .pf_pin(pf_pin), .pf_evt(pf_evt),
        .alarm_evt(alarm_evt), .tick_evt(tick_evt), .roll(roll),
        .osc_fail_evt(osc_fail_evt), .clk_start_wr(clk_start_wr),
        .osc_running(osc_running), .rdata(rdata), .blk_sel(blk_sel),
        .test_en(test_en), .single_supply(single_supply)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; d = rdata;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_roll(input logic [5:0] p);
        @(negedge clk); roll = p;
        @(negedge clk); roll = '0;
    endtask

    task automatic clear_osc();
        @(negedge clk); osc_running = 1'b1; clk_start_wr = 1'b1;
        @(negedge clk); clk_start_wr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 blk_sel", {7'd0, blk_sel}, 8'h00);
        check("R1 test_en", {7'd0, test_en}, 8'h00);
        check("R1 single_supply", {7'd0, single_supply}, 8'h01);
        do_read(5'd0, got); check("R1 status", got, 8'h00);
        do_read(5'd3, got); check("R1 flags", got, 8'h40);

        // R8 oscillator-fail flag
        @(negedge clk); clk_start_wr = 1'b1;
        @(negedge clk); clk_start_wr = 1'b0;
        do_read(5'd3, got); check("R8 no clear while stopped", got, 8'h40);
        clear_osc();
        do_read(5'd3, got); check("R8 clear when running", got, 8'h00);
        @(negedge clk); osc_fail_evt = 1'b1;
        @(negedge clk); osc_fail_evt = 1'b0;
        do_read(5'd3, got); check("R8 fail sets", got, 8'h40);
        clear_osc();

        // R9 supply mode
        do_write(5'd3, 8'h00);
        check("R9 battery mode", {7'd0, single_supply}, 8'h00);
        do_read(5'd3, got); check("R9 write leaves osc flag", got, 8'h00);
        do_write(5'd3, 8'h40);
        check("R9 single mode", {7'd0, single_supply}, 8'h01);
        do_write(5'd3, 8'h00);
        @(negedge clk); osc_fail_evt = 1'b1;
        @(negedge clk); osc_fail_evt = 1'b0;
        check("R9 forced by fail", {7'd0, single_supply}, 8'h01);
        clear_osc();

        // R7 rollover vector table
        for (int i = 0; i < 9; i++) begin
            pulse_roll(VEC[i][13:8]);
            do_read(5'd3, got); check("R7 flag read", got, VEC[i][7:0]);
            do_read(5'd3, got); check("R7 cleared after read", got, 8'h00);
        end
        pulse_roll(6'h05);
        do_write(5'd3, 8'h00);
        do_read(5'd3, got); check("R7 write ignored", got, 8'h05);

        // R2 decode and block select
        do_write(5'd0, 8'h40);
        do_read(5'd0, got); check("R2 status in block 1", got, 8'h40);
        pulse_roll(6'h01);
        do_read(5'd3, got); check("R2 flags hidden in block 1", got, 8'h00);
        do_read(5'd9, got); check("R2 unmapped address", got, 8'h00);
        do_write(5'd0, 8'h00);
        do_read(5'd3, got); check("R2 hidden read cleared nothing", got, 8'h01);

        // R3 live interrupt summary
        irq_pend = 1'b1;
        do_read(5'd0, got); check("R3 irq_pend", got, 8'h01);
        irq_pend = 1'b0; mfo_pend = 1'b1;
        do_read(5'd0, got); check("R3 mfo_pend", got, 8'h01);
        mfo_pend = 1'b0;
        do_read(5'd0, got); check("R3 none", got, 8'h00);

        // R4 write-one-to-clear causes
        @(negedge clk); alarm_evt = 1'b1;
        @(negedge clk); alarm_evt = 1'b0;
        do_read(5'd0, got); check("R4 alarm sets", got, 8'h04);
        do_read(5'd0, got); check("R4 read keeps", got, 8'h04);
        do_write(5'd0, 8'h00);
        do_read(5'd0, got); check("R4 zero write keeps", got, 8'h04);
        @(negedge clk); tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
        do_read(5'd0, got); check("R4 tick sets", got, 8'h0C);
        do_write(5'd0, 8'h04);
        do_read(5'd0, got); check("R4 clear bit 2", got, 8'h08);
        do_write(5'd0, 8'h08);
        do_read(5'd0, got); check("R4 clear bit 3", got, 8'h00);

        // R5 power-fail bit
        @(negedge clk); pf_pin = 1'b0; pf_evt = 1'b1;
        @(negedge clk); pf_evt = 1'b0;
        do_read(5'd0, got); check("R5 event sets", got, 8'h02);
        do_write(5'd0, 8'h02);
        do_read(5'd0, got); check("R5 write ignored", got, 8'h02);
        @(negedge clk); pf_pin = 1'b1;
        @(negedge clk);
        do_read(5'd0, got); check("R5 pin clears", got, 8'h00);
        @(negedge clk); pf_evt = 1'b1;
        @(negedge clk); pf_evt = 1'b0;
        do_read(5'd0, got); check("R5 held clear by pin", got, 8'h00);

        // R6 control bits
        do_write(5'd0, 8'h80);
        check("R6 test_en", {7'd0, test_en}, 8'h01);
        do_read(5'd0, got); check("R6 read bit 7", got, 8'h80);
        do_write(5'd0, 8'h30);
        do_read(5'd0, got); check("R6 bits 4-5 read zero", got, 8'h00);
        check("R6 test_en off", {7'd0, test_en}, 8'h00);

        // R10 set beats W1C in the same cycle
        @(negedge clk); addr = 5'd0; wdata = 8'h04; wr_stb = 1'b1; alarm_evt = 1'b1;
        @(negedge clk); wr_stb = 1'b0; alarm_evt = 1'b0;
        @(negedge clk);
        do_read(5'd0, got); check("R10 alarm beats clear", got, 8'h04);
        do_write(5'd0, 8'h04);
        // R10 rollover during the clear cycle
        pulse_roll(6'h01);
        @(negedge clk); addr = 5'd3; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; got = rdata;
        check("R10 pre-clear value", got, 8'h01);
        @(negedge clk); roll = 6'h01;
        @(negedge clk); roll = '0;
        do_read(5'd3, got); check("R10 roll beats read clear", got, 8'h01);
        do_read(5'd3, got); check("R10 then cleared", got, 8'h00);
        // R10 fail event beats oscillator clear
        @(negedge clk); osc_fail_evt = 1'b1; clk_start_wr = 1'b1;
        @(negedge clk); osc_fail_evt = 1'b0; clk_start_wr = 1'b0;
        do_read(5'd3, got); check("R10 fail beats clear", got, 8'h40);
        clear_osc();

        // R11 strobe handling
        @(negedge clk); addr = 5'd0; wdata = 8'h40; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0; got = rdata;
        @(negedge clk); @(negedge clk);
        check("R11 read served", got, 8'h00);
        check("R11 write dropped", {7'd0, blk_sel}, 8'h00);
        @(negedge clk); addr = 5'd3; alarm_evt = 1'b1;
        @(negedge clk); alarm_evt = 1'b0;
        check("R11 rdata held", rdata, 8'h00);
        @(negedge clk); addr = 5'd0; wdata = 8'h04; wr_stb = 1'b1;
        @(negedge clk);
        @(negedge clk); alarm_evt = 1'b1;
        @(negedge clk); alarm_evt = 1'b0;
        @(negedge clk); wr_stb = 1'b0;
        @(negedge clk);
        do_read(5'd0, got); check("R11 one write per strobe", got, 8'h04);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule